// File: doc/BRIEF.md
# Limit-Compare Interval Timer

This block is a memory-mapped interval timer with one interrupt output. A built-in prescaler divides the system clock into a 500 ns tick. Each tick adds one unit to a count that sits at bit 9 and up of a 32-bit word. The count is compared with a programmed limit. When the count reaches the limit, the count reloads to zero and a sticky reached flag is set. That flag drives the interrupt line, so interrupts repeat at the period the limit sets.

Software programs the limit in one of two ways. One write restarts the count. The other leaves the count running. Software reads the count through the counter word, whose top bit carries the reached flag, and acknowledges the interrupt by reading the limit word. A limit of zero makes the timer run freely across its whole range. The register port is a single-cycle strobe interface: read data is combinational on the addressed word, and write and read side effects take place at the clock edge where the strobe is high.

Top module: `interval_timer`

## Requirements
- R1: The register index is the byte address shifted right by two, so address bits 1:0 are ignored. Index 0 is the limit word with restart. Index 1 is the counter word. Index 2 is the limit word without restart. Index 3 is the status word.
- R2: A counter read returns the count in bits (9+CNT_W-1):9, the reached flag in bit 31, and zero in every other bit. Each tick that does not hit the limit adds one to the count.
- R3: A tick occurs every TICK_DIV clock cycles. The first tick comes on the TICK_DIV-th rising edge after reset is released.
- R4: On the tick where the count would become equal to the effective limit, the count reloads to zero and the reached flag and `irq` go high. They stay high until they are cleared, and they never rise without such a tick.
- R5: A read of index 0 returns the stored limit and clears the flag and `irq`. If a limit hit happens in the same cycle, the hit wins.
- R6: A write to index 0 stores the write data ANDed with the count-field mask (0x7FFFFE00 at the default width), sets the count to zero and clears the flag and `irq`. It takes priority over a tick in the same cycle.
- R7: A write to index 2 stores the masked limit in the same way but leaves the count and the flag as they are.
- R8: A stored limit of zero acts as the all-ones maximum count. The count then runs up to the maximum, reloads to zero and raises the flag there.
- R9: If the limit is set below the current count without a restart, the count climbs to all-ones, wraps to zero without setting the flag, and then counts up to the limit.
- R10: After a synchronous active-low reset, the limit, count and flag are zero, `irq` is low, and counting starts at once.
- R11: A status read returns 1, meaning the counter is always running. Reads of indices 4 and above return zero. Writes to index 1, index 3 or any undefined index change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Access strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed word |
| irq | output | 1 | Interrupt, high while the reached flag is set |

## Verification
The bench runs with a narrow count field and a three-cycle tick so that wraps and the free-running range can be reached. A cycle-accurate reference model in the bench predicts every read value and the state of `irq`. Directed sequences cover four cases that each isolate one mechanism: short periodic limits, which separate reload-on-hit from free counting; a limit lowered below the count without restart, which exposes the natural wrap; a zero limit, which exposes the full-range reload; and aliased or undefined addresses, which test the decode. A seeded random mix of reads, both kinds of limit write and stray writes then brings together acknowledges, hits and restarts in the same cycle, which separates the priority order among them.

// File: rtl/it_pkg.sv
// Shared constants and types for the interval timer.
// Assumes a 32-bit data word and a count field whose lowest bit is bit 9.
package it_pkg;
    localparam int WORD_W   = 32;
    localparam int UNIT_LSB = 9;

    localparam int IDX_LIMIT      = 0;
    localparam int IDX_COUNT      = 1;
    localparam int IDX_LIMIT_KEEP = 2;
    localparam int IDX_STATUS     = 3;

    typedef struct packed {
        logic wr_restart;
        logic wr_keep;
        logic rd_limit;
    } it_cmd_t;
endpackage

// File: rtl/it_tick_gen.sv
// Divides the clock into a one-cycle tick every TICK_DIV cycles.
// Assumes a synchronous active-low reset. The first tick comes TICK_DIV edges after release.
module it_tick_gen #(
    parameter int TICK_DIV = 50
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    generate
        if (TICK_DIV <= 1) begin : g_every
            assign tick = 1'b1;
        end else begin : g_div
            localparam int DW = $clog2(TICK_DIV);
            localparam logic [DW-1:0] LAST = DW'(TICK_DIV - 1);
            logic [DW-1:0] div_q;

            // divider phase, wraps after the last cycle of each period
            always_ff @(posedge clk) begin
                if (!rst_n)
                    div_q <= '0;
                else if (div_q == LAST)
                    div_q <= '0;
                else
                    div_q <= div_q + 1'b1;
            end

            assign tick = (div_q == LAST);
        end
    endgenerate
endmodule

// File: rtl/it_reg_decode.sv
// Turns a bus strobe into command pulses and selects the read word.
// Assumes a single-cycle access. Read data is combinational on the current state.
module it_reg_decode
    import it_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 22
) (
    input  logic                bus_valid,
    input  logic                bus_write,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [WORD_W-1:0]   limit_q,
    input  logic [CNT_W-1:0]    count_q,
    input  logic                flag_q,
    output it_cmd_t             cmd,
    output logic [WORD_W-1:0]   rdata
);
    logic [ADDR_W-1:0] word_idx;
    logic [WORD_W-1:0] count_word;

    assign word_idx = bus_addr >> 2;

    // command strobes from index and direction
    always_comb begin
        cmd.wr_restart = bus_valid &&  bus_write && (word_idx == ADDR_W'(IDX_LIMIT));
        cmd.wr_keep    = bus_valid &&  bus_write && (word_idx == ADDR_W'(IDX_LIMIT_KEEP));
        cmd.rd_limit   = bus_valid && !bus_write && (word_idx == ADDR_W'(IDX_LIMIT));
    end

    // build the counter word: flag on top, count in its field
    always_comb begin
        count_word                   = '0;
        count_word[WORD_W-1]         = flag_q;
        count_word[UNIT_LSB +: CNT_W] = count_q;
    end

    // read multiplexer over the defined indices
    always_comb begin
        if (word_idx == ADDR_W'(IDX_LIMIT))
            rdata = limit_q;
        else if (word_idx == ADDR_W'(IDX_COUNT))
            rdata = count_word;
        else if (word_idx == ADDR_W'(IDX_STATUS))
            rdata = WORD_W'(1);
        else
            rdata = '0;
    end
endmodule

// File: rtl/it_count_core.sv
// Holds the limit, the count and the sticky reached flag, and does the compare.
// Assumes at most one command per cycle. A restart beats a tick, and a hit beats a read-clear.
module it_count_core
    import it_pkg::*;
#(
    parameter int CNT_W = 22
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  it_cmd_t             cmd,
    input  logic [WORD_W-1:0]   wr_word,
    output logic [WORD_W-1:0]   limit_q,
    output logic [CNT_W-1:0]    count_q,
    output logic                flag_q,
    output logic                hit
);
    localparam logic [WORD_W-1:0] LIMIT_MASK = WORD_W'(((64'd1 << CNT_W) - 1) << UNIT_LSB);
    localparam logic [CNT_W-1:0]  MAX_UNITS  = '1;

    logic [CNT_W-1:0] lim_units;
    logic [CNT_W-1:0] eff_units;
    logic [CNT_W-1:0] inc;

    assign lim_units = limit_q[UNIT_LSB +: CNT_W];
    assign eff_units = (lim_units == '0) ? MAX_UNITS : lim_units;
    assign inc       = count_q + 1'b1;
    assign hit       = tick && (inc == eff_units);

    // stored limit, replaced by either kind of limit write
    always_ff @(posedge clk) begin
        if (!rst_n)
            limit_q <= '0;
        else if (cmd.wr_restart || cmd.wr_keep)
            limit_q <= wr_word & LIMIT_MASK;
    end

    // count: restart, reload on hit, or step on tick
    always_ff @(posedge clk) begin
        if (!rst_n)
            count_q <= '0;
        else if (cmd.wr_restart)
            count_q <= '0;
        else if (hit)
            count_q <= '0;
        else if (tick)
            count_q <= inc;
    end

    // sticky reached flag
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (cmd.wr_restart)
            flag_q <= 1'b0;
        else if (hit)
            flag_q <= 1'b1;
        else if (cmd.rd_limit)
            flag_q <= 1'b0;
    end
endmodule

// File: rtl/interval_timer.sv
// Top of the interval timer: prescaler, register decode and count core.
// Assumes CNT_W + 9 < 32 and a clock of TICK_DIV cycles per 500 ns.
module interval_timer
    import it_pkg::*;
#(
    parameter int TICK_DIV = 50,
    parameter int CNT_W    = 22,
    parameter int ADDR_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_valid,
    input  logic               bus_write,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic               irq
);
    it_cmd_t           cmd;
    logic              tick_w;
    logic              hit_w;
    logic              flag_w;
    logic [CNT_W-1:0]  count_w;
    logic [31:0]       limit_w;

    it_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick_w)
    );

    it_reg_decode #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dec (
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .limit_q   (limit_w),
        .count_q   (count_w),
        .flag_q    (flag_w),
        .cmd       (cmd),
        .rdata     (bus_rdata)
    );

    it_count_core #(.CNT_W(CNT_W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_w),
        .cmd     (cmd),
        .wr_word (bus_wdata),
        .limit_q (limit_w),
        .count_q (count_w),
        .flag_q  (flag_w),
        .hit     (hit_w)
    );

    assign irq = flag_w;
endmodule

// File: rtl/it_checker.sv
// Properties of the interval timer, attached to the top by bind.
// Relates bus strobes, the tick, the hit pulse and the count to later irq and count values.
module it_checker #(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 22
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_rdata,
    input logic              irq,
    input logic              tick,
    input logic              hit,
    input logic [CNT_W-1:0]  count
);
    logic [ADDR_W-1:0] idx;
    logic              acc0;
    logic              wr0;
    assign idx  = bus_addr >> 2;
    assign acc0 = bus_valid && (idx == '0);
    assign wr0  = acc0 && bus_write;

    p_restart_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr0 |=> (!irq && count == '0));

    p_keep_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write && idx == ADDR_W'(2) && !tick) |=> (count == $past(count)));

    p_read_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc0 && !bus_write && !hit) |=> !irq);

    p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !acc0) |=> irq);

    p_hit_raise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !wr0) |=> (irq && count == '0));

    p_rise_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(hit));

    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !hit && !wr0) |=> (count == $past(count) + 1'b1));

    p_low_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && idx == ADDR_W'(1)) |-> (bus_rdata[8:0] == 9'd0));

    p_undef_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && idx >= ADDR_W'(4)) |-> (bus_rdata == 32'd0));
endmodule

bind interval_timer it_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .tick      (tick_w),
    .hit       (hit_w),
    .count     (count_w)
);

// File: tb/tb_interval_timer.sv
// Self-checking bench: a cycle-accurate reference model built from the requirements,
// directed corner cases and a seeded random mix of accesses.
module tb_interval_timer;
    localparam int DIV  = 3;
    localparam int CW   = 8;
    localparam int AW   = 8;
    localparam logic [CW-1:0] MAXU = '1;
    localparam logic [31:0] MASK = 32'h0001FE00;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_valid = 1'b0;
    logic bus_write = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    interval_timer #(.TICK_DIV(DIV), .CNT_W(CW), .ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    // reference model state
    int            m_div;
    logic [CW-1:0] m_cnt;
    logic [31:0]   m_lim;
    logic          m_flag;

    // model update at each rising edge from the inputs the bench drove
    always @(posedge clk) begin : model
        logic tk, hit, wr_r, wr_k, rd_l;
        logic [CW-1:0] effu, inc;
        int idx;
        if (!rst_n) begin
            m_div <= 0; m_cnt <= '0; m_lim <= '0; m_flag <= 1'b0;
        end else begin
            idx  = int'(bus_addr >> 2);
            wr_r = bus_valid && bus_write && idx == 0;
            wr_k = bus_valid && bus_write && idx == 2;
            rd_l = bus_valid && !bus_write && idx == 0;
            tk   = (m_div == DIV - 1);
            m_div <= tk ? 0 : m_div + 1;
            effu = (m_lim[9 +: CW] == '0) ? MAXU : m_lim[9 +: CW];
            inc  = m_cnt + 1'b1;
            hit  = tk && (inc == effu);
            if (wr_r || wr_k) m_lim <= bus_wdata & MASK;
            if (wr_r)       m_cnt <= '0;
            else if (hit)   m_cnt <= '0;
            else if (tk)    m_cnt <= inc;
            if (wr_r)       m_flag <= 1'b0;
            else if (hit)   m_flag <= 1'b1;
            else if (rd_l)  m_flag <= 1'b0;
        end
    end

    function automatic logic [31:0] exp_rd(int idx);
        logic [31:0] r;
        r = '0;
        case (idx)
            0: r = m_lim;
            1: begin r[31] = m_flag; r[9 +: CW] = m_cnt; end
            3: r = 32'd1;
            default: r = '0;
        endcase
        return r;
    endfunction

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // one bus cycle: drive at the falling edge, compare shortly after
    task automatic op(bit v, bit w, int a, logic [31:0] d, string tag);
        @(negedge clk);
        bus_valid = v; bus_write = w; bus_addr = AW'(a); bus_wdata = d;
        #1;
        chk(irq === m_flag, "R4", 32'(irq), 32'(m_flag));
        if (v && !w)
            chk(bus_rdata === exp_rd(a >> 2), tag, bus_rdata, exp_rd(a >> 2));
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) op(0, 0, 0, 32'd0, "R4");
    endtask

    function automatic string tag_of(int idx);
        if (idx == 0) return "R5";
        if (idx == 1) return "R2";
        return "R11";
    endfunction

    initial begin : watchdog
        #1_000_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL R10 watchdog act=%h exp=%h", 32'd0, 32'd1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10: reset state
        op(1, 0, 0, 32'd0, "R10");
        chk(bus_rdata == 32'd0, "R10", bus_rdata, 32'd0);
        chk(irq == 1'b0, "R10", 32'(irq), 32'd0);
        op(1, 0, 4, 32'd0, "R10");
        // R3: count advances once per DIV cycles from reset
        idle(6);
        op(1, 0, 4, 32'd0, "R3");
        // R6: masked store and restart
        op(1, 1, 0, 32'hFFFF_FFFF, "R6");
        op(1, 0, 0, 32'd0, "R6");
        chk(bus_rdata == MASK, "R6", bus_rdata, MASK);
        op(1, 0, 4, 32'd0, "R6");
        // R4: short periodic limit
        op(1, 1, 0, 32'h0000_0800, "R4");
        idle(13);
        op(1, 0, 4, 32'd0, "R4");
        chk(irq == 1'b1, "R4", 32'(irq), 32'd1);
        idle(12);
        // R5: acknowledge through the limit read
        op(1, 0, 0, 32'd0, "R5");
        chk(bus_rdata == 32'h0000_0800, "R5", bus_rdata, 32'h800);
        op(0, 0, 0, 32'd0, "R5");
        chk(irq == 1'b0 || m_flag, "R5", 32'(irq), 32'd0);
        // R7: limit without restart keeps the count
        op(1, 1, 0, 32'h0000_C800, "R7");
        idle(30);
        op(1, 1, 8, 32'h0001_4000, "R7");
        op(1, 0, 4, 32'd0, "R7");
        op(1, 0, 0, 32'd0, "R7");
        idle(40);
        op(1, 0, 4, 32'd0, "R7");
        // R9: limit lowered below the count, wrap through the top
        op(1, 1, 0, 32'h0000_C800, "R9");
        idle(60);
        op(1, 1, 8, 32'h0000_0A00, "R9");
        op(1, 0, 0, 32'd0, "R9");
        for (int k = 0; k < 16; k++) begin
            idle(50);
            op(1, 0, 4, 32'd0, "R9");
        end
        // R8: zero limit runs the full range
        op(1, 1, 0, 32'd0, "R8");
        idle(760);
        op(1, 0, 4, 32'd0, "R8");
        idle(10);
        op(1, 0, 4, 32'd0, "R8");
        chk(irq == 1'b1, "R8", 32'(irq), 32'd1);
        // R1: low address bits ignored
        op(1, 0, 5, 32'd0, "R1");
        op(1, 0, 3, 32'd0, "R1");
        op(1, 1, 11, 32'h0000_0600, "R1");
        op(1, 0, 1, 32'd0, "R1");
        // R11: status, undefined reads, ignored writes
        op(1, 0, 12, 32'd0, "R11");
        chk(bus_rdata == 32'd1, "R11", bus_rdata, 32'd1);
        op(1, 0, 16, 32'd0, "R11");
        op(1, 0, 252, 32'd0, "R11");
        op(1, 1, 4, 32'hFFFF_FFFF, "R11");
        op(1, 1, 12, 32'hFFFF_FFFF, "R11");
        op(1, 1, 20, 32'hFFFF_FFFF, "R11");
        op(1, 0, 0, 32'd0, "R11");
        op(1, 0, 4, 32'd0, "R11");
        // random mix
        for (int n = 0; n < 3000; n++) begin
            int r, a;
            r = int'($urandom % 100);
            a = int'($urandom % 32);
            if (r < 45)
                op(0, 0, 0, 32'd0, "R4");
            else if (r < 70)
                op(1, 0, a, 32'd0, tag_of(a >> 2));
            else if (r < 80)
                op(1, 1, a & 3, ((32'($urandom % 30) + 1) << 9) | ($urandom & 32'hFFFE_01FF), "R6");
            else if (r < 90)
                op(1, 1, 8 | (a & 3), ((32'($urandom % 60)) << 9), "R7");
            else
                op(1, 1, 4 + a, $urandom, "R11");
        end
        idle(2);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule